// File: doc/BRIEF.md
# Fully Parallel Register Matrix Multiplier

This block computes the product of two square matrices of signed 18-bit values, up to N by N, using one multiply-accumulate cell per result element. The operands and the results all live in flip-flops. Every cell can therefore read any row of the left operand and any column of the right operand in the same cycle, and the whole product is finished after n accumulation cycles, where n is the size chosen at run time.

A host loads the left operand (A) and the right operand (B) one element per cycle through a write port addressed by matrix select, row and column. It then pulses start with the working size on `size_n`, waits for `done`, and reads result elements through a combinational read port addressed by row and column. Matrices smaller than N are placed in the top-left corner. Only that corner takes part in the sum, and the other result cells read as zero.

Top module: `sqmat_mul_par`

## Requirements
- R1: After reset, `busy` and `done` are 0 and every result cell reads 0.
- R2: When `wr_en` is 1 and `busy` is 0, a clock edge stores `wr_data` at (`wr_row`, `wr_col`) of A if `wr_sel` is 0, or of B if `wr_sel` is 1.
- R3: If `start` is 1 while `busy` is 0 at an edge E0, then `busy` is 1 and `done` is 0 after E0. After exactly n further edges, `busy` is 0 and `done` is 1. The two flags are never 1 together.
- R4: On completion, result cell (i,j) holds the low 18 bits, in two's complement, of the sum over k = 0..n-1 of A[i][k]·B[k][j]. The operands are signed, and overflow wraps.
- R5: Only the top-left n×n part of A and B affects the result. Cells with i ≥ n or j ≥ n read 0 after completion.
- R6: The working size n is taken from `size_n` at the accepted start. A value of 0 is treated as 1, and values above N are treated as N.
- R7: `done` stays at 1 until the next accepted start.
- R8: A `start` pulse while `busy` is 1 has no effect on the run length or on the result.
- R9: Operand writes while `busy` is 1 are discarded. The operand that would have been written keeps its old value.
- R10: `rd_data` follows `rd_row`/`rd_col` in the same cycle. Reads at a row or column of N or above return 0. Result cells change only at the completion edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Operand write strobe |
| wr_sel | input | 1 | 0 selects A, 1 selects B |
| wr_row | input | IW | Row index of the write |
| wr_col | input | IW | Column index of the write |
| wr_data | input | W | Signed element to store |
| size_n | input | SW | Working matrix size n |
| start | input | 1 | Begin a multiplication when idle |
| busy | output | 1 | Accumulation in progress |
| done | output | 1 | Result valid, held until the next start |
| rd_row | input | IW | Row index of the result read |
| rd_col | input | IW | Column index of the result read |
| rd_data | output | W | Result element, combinational |

## Verification
Two pairs of functions can meet in one cycle. A host write can land while the cells are accumulating, and a new start request can arrive while a run is still in progress. The bench provokes both by raising `start` and `wr_en` together, aimed at an element in the active corner, on the first busy cycle of a run. It judges the outcome in three ways. The run must still take n cycles. The finished result must match a model built from the original operands. A second run with no new writes must return the same values, which shows that the discarded write never reached the operand.

// File: rtl/sqmat_mul_par.sv
module sqmat_mul_par #(
  parameter int N = 4,
  parameter int W = 18,
  localparam int IW = (N > 1) ? $clog2(N) : 1,
  localparam int SW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [IW-1:0] wr_row,
  input  logic [IW-1:0] wr_col,
  input  logic [W-1:0]  wr_data,
  input  logic [SW-1:0] size_n,
  input  logic          start,
  output logic          busy,
  output logic          done,
  input  logic [IW-1:0] rd_row,
  input  logic [IW-1:0] rd_col,
  output logic [W-1:0]  rd_data
);
  localparam int AW  = 2 * W + IW + 1;
  localparam int AIW = (N > 1) ? $clog2(N * N) : 1;

  logic signed [W-1:0] a_m [N][N];
  logic signed [W-1:0] b_m [N][N];
  logic [W-1:0]        res_arr [N*N];

  logic          busy_q, done_q;
  logic [IW-1:0] k_q;
  logic [SW-1:0] n_q, n_eff;
  logic          go, last;

  assign go   = start & ~busy_q;
  assign last = busy_q && (int'(k_q) == int'(n_q) - 1);

  always_comb begin
    if (size_n == '0)          n_eff = SW'(1);
    else if (int'(size_n) > N) n_eff = SW'(N);
    else                       n_eff = size_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < N; r++)
        for (int c = 0; c < N; c++) begin
          a_m[r][c] <= '0;
          b_m[r][c] <= '0;
        end
    end else if (wr_en && !busy_q && int'(wr_row) < N && int'(wr_col) < N) begin
      if (wr_sel) b_m[wr_row][wr_col] <= wr_data;
      else        a_m[wr_row][wr_col] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      k_q    <= '0;
      n_q    <= SW'(1);
    end else if (go) begin
      busy_q <= 1'b1;
      done_q <= 1'b0;
      k_q    <= '0;
      n_q    <= n_eff;
    end else if (busy_q) begin
      if (last) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else begin
        k_q <= k_q + 1'b1;
      end
    end
  end

  for (genvar gi = 0; gi < N; gi++) begin : g_row
    for (genvar gj = 0; gj < N; gj++) begin : g_cell
      logic signed [2*W-1:0] prod;
      logic signed [AW-1:0]  acc_q, sum;
      logic [W-1:0]          res_q;
      logic                  in_rng;

      assign prod   = a_m[gi][k_q] * b_m[k_q][gj];
      assign sum    = acc_q + {{(AW-2*W){prod[2*W-1]}}, prod};
      assign in_rng = (gi < int'(n_q)) && (gj < int'(n_q));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          acc_q <= '0;
          res_q <= '0;
        end else if (go) begin
          acc_q <= '0;
        end else if (busy_q) begin
          acc_q <= sum;
          if (last) res_q <= in_rng ? sum[W-1:0] : '0;
        end
      end

      assign res_arr[gi*N+gj] = res_q;
    end
  end

  logic           rd_ok;
  logic [AIW-1:0] rd_idx;
  assign rd_ok   = (int'(rd_row) < N) && (int'(rd_col) < N);
  assign rd_idx  = AIW'(int'(rd_row) * N + int'(rd_col));
  assign rd_data = rd_ok ? res_arr[rd_idx] : '0;

  assign busy = busy_q;
  assign done = done_q;
endmodule

// File: rtl/sqmat_mul_par_chk.sv
module sqmat_mul_par_chk #(
  parameter int N = 4,
  parameter int W = 18,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic [IW-1:0] rd_row,
  input logic [IW-1:0] rd_col,
  input logic [W-1:0]  rd_data
);
  AST_START_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy && !done); // R3
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done)); // R3
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done); // R7
  AST_BUSY_START_IGN: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> busy || done); // R8
  AST_READ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !$past(busy) && $stable(rd_row) && $stable(rd_col) |-> $stable(rd_data)); // R10
endmodule

bind sqmat_mul_par sqmat_mul_par_chk #(.N(N), .W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .rd_row(rd_row), .rd_col(rd_col), .rd_data(rd_data)
);

// File: tb/sqmat_mul_par_tb.sv
module sqmat_mul_par_tb_top;
  localparam int  N  = 4;
  localparam int  W  = 18;
  localparam time TCLK = 10ns;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       wr_en = 1'b0, wr_sel = 1'b0, start = 1'b0;
  logic [1:0] wr_row = '0, wr_col = '0, rd_row = '0, rd_col = '0;
  logic [W-1:0] wr_data = '0;
  logic [2:0] size_n = 3'd4;
  logic       busy, done;
  logic [W-1:0] rd_data;

  int total = 0, bad = 0;
  int ma [N][N];
  int mb [N][N];
  int unsigned seed = 32'h1234_5678;

  always #(TCLK/2) clk = ~clk;

  sqmat_mul_par #(.N(N), .W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_row(wr_row), .wr_col(wr_col), .wr_data(wr_data), .size_n(size_n),
    .start(start), .busy(busy), .done(done),
    .rd_row(rd_row), .rd_col(rd_col), .rd_data(rd_data)
  );

  task automatic check(string req, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'((seed >> 8) % 262144) - 131072;
  endfunction

  function automatic logic [W-1:0] exp_cell(int i, int j, int n);
    longint s = 0;
    if (i >= n || j >= n) return '0;
    for (int k = 0; k < n; k++) s += longint'(ma[i][k]) * longint'(mb[k][j]);
    return s[W-1:0];
  endfunction

  task automatic wr(bit sel, int r, int c, int v);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_row = 2'(r); wr_col = 2'(c); wr_data = W'(v);
    @(negedge clk);
    wr_en = 1'b0;
    if (sel) mb[r][c] = v; else ma[r][c] = v;
  endtask

  task automatic rd(int r, int c, output logic [W-1:0] v);
    rd_row = 2'(r); rd_col = 2'(c);
    #1 v = rd_data;
  endtask

  task automatic load(int mode);
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        wr(1'b0, r, c, mode == 1 ? 131071 : (mode == 2 ? -131072 : rnd()));
        wr(1'b1, r, c, mode == 1 ? 131071 : rnd());
      end
  endtask

  task automatic run(int sz, int n, bit poke, string req);
    int cyc = 0;
    @(negedge clk);
    size_n = 3'(sz); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check({req, " busy after start"}, busy, 1);
    check({req, " done cleared"}, done, 0);
    if (poke) begin
      start = 1'b1; wr_en = 1'b1; wr_sel = 1'b0; wr_row = 0; wr_col = 0; wr_data = W'(777);
      @(negedge clk);
      start = 1'b0; wr_en = 1'b0; cyc = 1;
    end
    while (!done && cyc < 50) begin
      if (busy && done) check({req, " flags exclusive"}, 1, 0);
      @(negedge clk);
      cyc++;
    end
    check({req, " run length"}, cyc, n);
    check({req, " busy low at end"}, busy, 0);
  endtask

  task automatic check_res(int n, string req);
    logic [W-1:0] v;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        rd(i, j, v);
        check(req, v, exp_cell(i, j, n));
      end
  endtask

  task automatic t_reset();
    logic [W-1:0] v;
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        rd(i, j, v);
        check("R1 cell", v, 0);
      end
  endtask

  task automatic t_full();
    load(0);
    run(4, 4, 1'b0, "R3");
    check_res(4, "R4 R2 full product");
    load(0);
    run(4, 4, 1'b0, "R3");
    check_res(4, "R4 second pattern");
  endtask

  task automatic t_small();
    load(0);
    run(2, 2, 1'b0, "R3 n=2");
    check_res(2, "R5 corner n=2");
    run(3, 3, 1'b0, "R3 n=3");
    check_res(3, "R5 corner n=3");
  endtask

  task automatic t_wrap();
    load(1);
    run(4, 4, 1'b0, "R3");
    check_res(4, "R4 wrap positive");
    load(2);
    run(4, 4, 1'b0, "R3");
    check_res(4, "R4 wrap mixed sign");
  endtask

  task automatic t_clamp();
    load(0);
    run(0, 1, 1'b0, "R6 size 0");
    check_res(1, "R6 size 0 result");
    run(7, 4, 1'b0, "R6 size 7");
    check_res(4, "R6 size 7 result");
  endtask

  task automatic t_busy();
    load(0);
    run(4, 4, 1'b1, "R8 start while busy");
    check_res(4, "R9 write during busy");
    repeat (3) @(negedge clk);
    check("R7 done held", done, 1);
    run(4, 4, 1'b0, "R9 rerun");
    check_res(4, "R9 operand unchanged");
  endtask

  task automatic t_read();
    logic [W-1:0] v0, v1;
    rd(1, 2, v0);
    check("R10 comb read", v0, exp_cell(1, 2, 4));
    rd(3, 0, v1);
    check("R10 comb read switch", v1, exp_cell(3, 0, 4));
    repeat (2) @(negedge clk);
    rd(3, 0, v1);
    check("R10 stable when idle", v1, exp_cell(3, 0, 4));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full();
    t_read();
    t_small();
    t_wrap();
    t_clamp();
    t_busy();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL R3 watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule